// File: doc/BRIEF.md
# Strided Memory Stream Address Generator

This block expands a single stream command into a sequence of memory read addresses that walk a two-dimensional strided region. A command names a start address, a stride, a run length and a run count. The block issues the run length in consecutive 16-bit words starting at the run's first address. It then moves to the next run, whose first address lies one stride beyond the first address of the run before it. It stops after the given number of runs.

Alongside every memory address the block produces a scratchpad destination address. These addresses start at a programmable offset and climb by one word per request, with no gaps, across all runs. A strided region of main memory is therefore packed densely into a 4 KB local scratchpad. The addresses wrap around at the end of the scratchpad.

A valid/ready command port takes a command only while no stream is active. A valid/ready request port presents each address pair. A one-cycle done pulse marks the end of each command. The block moves no data and holds no storage array.

Top module: `strm_addr_walker`

## Requirements
- R1: After reset, cmd_ready is 1 and req_valid and done are 0.
- R2: The first request of a non-empty command carries req_mem_addr equal to cmd_base and req_spad_addr equal to cmd_spad_off.
- R3: Inside one run, each accepted request is followed by a request whose memory address is 2 bytes higher, modulo 2^ADDR_W.
- R4: The first request of every run after the first has the memory address of the previous run's first request plus cmd_stride, modulo 2^ADDR_W.
- R5: A command with run length L (in 16-bit words) and run count N issues exactly L*N requests. req_last is 1 on the final request only.
- R6: The scratchpad address is a byte address 12 bits wide. It rises by 2 after every accepted request, across run boundaries too, and wraps modulo 4096.
- R7: done is 1 for exactly one cycle: the cycle after the final request is accepted. In that same cycle req_valid is 0 and cmd_ready is 1.
- R8: While a stream is active, cmd_ready is 0, and a command presented on the command port does not change the request sequence.
- R9: A command with zero run length or zero run count issues no request. done is 1 in the cycle after the command is accepted.
- R10: While req_valid is 1 and req_ready is 0, the next cycle keeps req_valid at 1 and both addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_base | input | ADDR_W | Byte address of the first word of the first run |
| cmd_stride | input | ADDR_W | Byte distance between the first addresses of consecutive runs |
| cmd_len | input | LEN_W | Words per run |
| cmd_rows | input | CNT_W | Number of runs |
| cmd_spad_off | input | SP_W | First scratchpad byte address |
| req_valid | output | 1 | Address pair present |
| req_ready | input | 1 | Consumer takes the address pair |
| req_mem_addr | output | ADDR_W | Memory read byte address |
| req_spad_addr | output | SP_W | Scratchpad write byte address |
| req_last | output | 1 | Final request of the command |
| done | output | 1 | One-cycle completion pulse |

## Verification
A plain dense pattern with the consumer always ready shows that the in-run increment and the stride jump are kept apart. An alternating ready pattern shows that backpressure holds the address pair without skipping or repeating a word. A large stride with a scratchpad offset near the top shows that the memory address wraps independently of the scratchpad address, which wraps at 4 KB. Zero-length, zero-count, single-word and mid-stream command intrusion cases cover the boundary cases and the idle-only acceptance rule.

// File: rtl/strm_pkg.sv
package strm_pkg;
  localparam int WORD_BYTES = 2;
  typedef enum logic {ST_IDLE, ST_RUN} strm_state_e;
endpackage

// File: rtl/strm_counter.sv
module strm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  input  logic         step,
  output logic         at_last
);
  logic [W-1:0] cnt_q, cnt_d, lim_q, lim_d;

  assign at_last = (cnt_q == (lim_q - W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load) begin
      cnt_d = '0;
      lim_d = limit;
    end else if (step) begin
      cnt_d = at_last ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load || step) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/strm_ctrl.sv
module strm_ctrl
  import strm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_empty,
  input  logic hs,
  input  logic elem_last,
  input  logic row_last,
  output logic cmd_ready,
  output logic req_valid,
  output logic load,
  output logic done
);
  strm_state_e state_q, state_d;
  logic        done_d;

  assign cmd_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_RUN);
  assign load      = cmd_valid && cmd_ready;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_valid) begin
        if (cmd_empty) done_d  = 1'b1;
        else           state_d = ST_RUN;
      end
      ST_RUN: if (hs && elem_last && row_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/strm_addr_walker.sv
module strm_addr_walker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 16,
  parameter int SPAD_BYTES = 4096,
  parameter int SP_W       = $clog2(SPAD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [CNT_W-1:0]  cmd_rows,
  input  logic [SP_W-1:0]   cmd_spad_off,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_mem_addr,
  output logic [SP_W-1:0]   req_spad_addr,
  output logic              req_last,
  output logic              done
);
  localparam logic [ADDR_W-1:0] MEM_STEP = ADDR_W'(strm_pkg::WORD_BYTES);
  localparam logic [SP_W-1:0]   SP_STEP  = SP_W'(strm_pkg::WORD_BYTES);

  logic load, hs, elem_last, row_last, cmd_empty;
  logic [ADDR_W-1:0] mem_q, mem_d, row_q, row_d, stride_q, stride_d;
  logic [SP_W-1:0]   spad_q, spad_d;

  assign cmd_empty     = (cmd_len == '0) || (cmd_rows == '0);
  assign hs            = req_valid && req_ready;
  assign req_mem_addr  = mem_q;
  assign req_spad_addr = spad_q;
  assign req_last      = req_valid && elem_last && row_last;

  strm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_empty(cmd_empty),
    .hs(hs), .elem_last(elem_last), .row_last(row_last),
    .cmd_ready(cmd_ready), .req_valid(req_valid), .load(load), .done(done)
  );

  strm_counter #(.W(LEN_W)) u_elem_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .limit(cmd_len),
    .step(hs), .at_last(elem_last)
  );

  strm_counter #(.W(CNT_W)) u_row_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .limit(cmd_rows),
    .step(hs && elem_last), .at_last(row_last)
  );

  always_comb begin
    mem_d    = mem_q;
    row_d    = row_q;
    stride_d = stride_q;
    spad_d   = spad_q;
    if (load) begin
      mem_d    = cmd_base;
      row_d    = cmd_base;
      stride_d = cmd_stride;
      spad_d   = cmd_spad_off;
    end else if (hs) begin
      spad_d = spad_q + SP_STEP;
      if (elem_last) begin
        row_d = row_q + stride_q;
        mem_d = row_q + stride_q;
      end else begin
        mem_d = mem_q + MEM_STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '0;
      row_q    <= '0;
      stride_q <= '0;
      spad_q   <= '0;
    end else if (load || hs) begin
      mem_q    <= mem_d;
      row_q    <= row_d;
      stride_q <= stride_d;
      spad_q   <= spad_d;
    end
  end
endmodule

// File: rtl/strm_addr_walker_chk.sv
module strm_addr_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SP_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [CNT_W-1:0]  cmd_rows,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_mem_addr,
  input logic [SP_W-1:0]   req_spad_addr,
  input logic              req_last,
  input logic              done,
  input logic              elem_last
);
  // R3
  in_run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !elem_last) |=>
      (req_mem_addr == $past(req_mem_addr) + ADDR_W'(2)));
  // R6
  spad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=>
      (req_spad_addr == $past(req_spad_addr) + SP_W'(2)));
  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_last) |=> (done && !req_valid && cmd_ready));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);
  // R9
  empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_len == '0 || cmd_rows == '0)) |=>
      (done && !req_valid));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_mem_addr) && $stable(req_spad_addr)));
endmodule

bind strm_addr_walker strm_addr_walker_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .cmd_rows(cmd_rows), .req_valid(req_valid),
  .req_ready(req_ready), .req_mem_addr(req_mem_addr),
  .req_spad_addr(req_spad_addr), .req_last(req_last), .done(done),
  .elem_last(elem_last)
);

// File: tb/strm_addr_walker_test.sv
module strm_addr_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0, cmd_stride = '0;
  logic [15:0] cmd_len = '0, cmd_rows = '0;
  logic [11:0] cmd_spad_off = '0;
  logic        req_valid, req_ready = 1'b0, req_last, done;
  logic [31:0] req_mem_addr;
  logic [11:0] req_spad_addr;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  strm_addr_walker uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .cmd_rows(cmd_rows), .cmd_spad_off(cmd_spad_off), .req_valid(req_valid),
    .req_ready(req_ready), .req_mem_addr(req_mem_addr),
    .req_spad_addr(req_spad_addr), .req_last(req_last), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] b, input logic [31:0] s, input logic [15:0] l,
                       input logic [15:0] r, input logic [11:0] o);
    @(negedge clk);
    cmd_base = b; cmd_stride = s; cmd_len = l; cmd_rows = r; cmd_spad_off = o;
    cmd_valid = 1'b1;
    #1 check("R8 idle cmd_ready", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // mode 0: always ready, 1: alternating ready, 2: ready with a command pushed mid-stream
  task automatic run_stream(input logic [31:0] b, input logic [31:0] s, input int l,
                            input int r, input logic [11:0] o, input int mode);
    int idx = 0, guard = 0, total = l * r;
    issue(b, s, 16'(l), 16'(r), o);
    while (idx < total && guard < 5000) begin
      req_ready = (mode == 1) ? guard[0] : 1'b1;
      if (mode == 2 && idx == 1 && cmd_valid == 1'b0 && guard < 3) begin
        #1 check("R8 busy cmd_ready", cmd_ready, 0);
        cmd_base = 32'hDEAD_0000; cmd_stride = 32'h10; cmd_len = 16'd1;
        cmd_rows = 16'd1; cmd_valid = 1'b1;
      end else begin
        cmd_valid = 1'b0;
      end
      #1;
      if (req_valid && req_ready) begin
        int row = idx / l, el = idx % l;
        logic [31:0] em = b + 32'(row) * s + 32'(2 * el);
        logic [11:0] es = o + 12'(2 * idx);
        if (idx == 0)      check("R2 first mem", req_mem_addr, em);
        else if (el == 0)  check("R4 run start mem", req_mem_addr, em);
        else               check("R3 in-run mem", req_mem_addr, em);
        check(idx == 0 ? "R2 first spad" : "R6 spad", {20'd0, req_spad_addr}, {20'd0, es});
        check("R5 last flag", req_last, idx == total - 1);
        idx++;
      end else if (!req_valid) begin
        check("R5 request missing", 0, 1);
      end
      @(negedge clk);
      guard++;
    end
    cmd_valid = 1'b0;
    req_ready = 1'b0;
    #1 check("R5 count", idx, total);
    check("R7 done pulse", done, 1);
    check("R7 req_valid off", req_valid, 0);
    check("R7 cmd_ready on", cmd_ready, 1);
    @(negedge clk);
    #1 check("R7 done cleared", done, 0);
    check("R8 no extra request", req_valid, 0);
  endtask

  task automatic run_empty(input logic [15:0] l, input logic [15:0] r);
    issue(32'h4000, 32'h100, l, r, 12'h20);
    #1 check("R9 done", done, 1);
    check("R9 no request", req_valid, 0);
    @(negedge clk);
    #1 check("R9 done cleared", done, 0);
    check("R9 still idle", req_valid, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    #1 check("R1 cmd_ready", cmd_ready, 1);
    check("R1 req_valid", req_valid, 0);
    check("R1 done", done, 0);
  endtask

  task automatic test_hold();
    issue(32'h0000_2000, 32'h80, 16'd3, 16'd1, 12'h0);
    req_ready = 1'b0;
    #1 check("R10 valid", req_valid, 1);
    @(negedge clk);
    #1 check("R10 held valid", req_valid, 1);
    check("R10 held mem", req_mem_addr, 32'h2000);
    check("R10 held spad", {20'd0, req_spad_addr}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      req_ready = 1'b1;
      @(negedge clk);
    end
    req_ready = 1'b0;
    #1 check("R7 hold done", done, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_stream(32'h0000_1000, 32'h40, 4, 3, 12'h000, 0);
    run_stream(32'h0001_0000, 32'h100, 3, 4, 12'h010, 1);
    run_stream(32'hFFFF_FF00, 32'h0000_0200, 2, 3, 12'hFFC, 0);
    run_stream(32'h0000_3000, 32'h20, 3, 2, 12'h100, 2);
    run_stream(32'h0000_0800, 32'h8, 1, 1, 12'h7FE, 0);
    run_empty(16'd0, 16'd5);
    run_empty(16'd4, 16'd0);
    test_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule